// File: doc/BRIEF.md
# Physical-to-Real Page Translation Cache

This block is a small fully associative translation cache that sits in a memory controller in front of a non-volatile main memory. A write can move a page to a new physical location in the memory array. Because of that, the system page number used by the processors differs from the real page number that holds the data. The cache keeps the most recent of these translations. A read request whose page is held gets its real page number one cycle later, with no software involvement. A read whose page is absent raises a request to a software handler and stalls until that handler fills in the mapping.

Every write request traps to software, whether or not its page is cached. The handler may choose a fresh real page for the written data. After the handler acts, it updates the cache through the fill port and removes stale mappings through the invalidate port. When all entries are valid, a new mapping displaces the least recently used one. Until then, free entries are taken first.

Top module: `pmc_map_cache`

## Requirements
- R1: After reset, req_ready is 1, and resp_valid and sw_req are 0. No entry is valid, so the first read of any page misses.
- R2: When a read is accepted (req_valid=1, req_write=0, req_ready=1) for a page whose mapping is held, the next cycle shows resp_valid=1, resp_hit=1 and resp_rpn equal to the cached real page number, with sw_req=0.
- R3: When an accepted read misses, sw_req=1, sw_write=0 and sw_ppn equal to the requested page are asserted from the next cycle, and req_ready=0. These values hold until a fill arrives for that page. Requests presented while req_ready=0 are ignored, and fills of other pages do not end the stall.
- R4: A fill whose page equals the stalled page gives, in the next cycle, resp_valid=1, resp_hit=0, resp_rpn equal to the filled real page, sw_req=0 and req_ready=1. The mapping is kept, so a later read of that page hits.
- R5: An accepted write asserts sw_req=1 and sw_write=1 with sw_ppn equal to its page for exactly one cycle, starting the next cycle. This happens whether the page is cached or not. It gives no resp_valid, does not drop req_ready and does not disturb cached mappings.
- R6: A fill of a page that is already held replaces its real page number in place, so no page is ever held twice.
- R7: After an invalidate of a page, reads of that page miss. A read accepted in the same cycle as an invalidate of its page also misses.
- R8: A fill to the same page as a read accepted in the same cycle takes priority. The read hits with the filled real page number and raises no software request.
- R9: A fill of a new page takes an invalid entry when one exists. Otherwise it evicts the entry least recently filled or read-hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | 1 = write request (always traps), 0 = read |
| req_ppn | input | PPN_W | Physical page number of the request |
| req_ready | output | 1 | Request accepted this cycle when high; low while a read miss stalls |
| resp_valid | output | 1 | Read result present |
| resp_hit | output | 1 | 1 = served from cache, 0 = completed by a fill |
| resp_rpn | output | RPN_W | Real page number for the read |
| sw_req | output | 1 | Software handler request |
| sw_write | output | 1 | 1 = write trap, 0 = read miss |
| sw_ppn | output | PPN_W | Physical page number the handler must service |
| fill_valid | input | 1 | Install or replace a mapping |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_rpn | input | RPN_W | Real page number of the fill |
| inv_valid | input | 1 | Remove a mapping |
| inv_ppn | input | PPN_W | Physical page number to remove |

## Verification
The bench checks that requests made during a miss stall are dropped and that unrelated fills leave the stall in place. A design that got this wrong would lose a request or end the stall early with a wrong real page. It checks same-cycle collisions: a fill racing a read of its page, which must hit with the new value, and an invalidate racing a read, which must miss. Getting either wrong would return a stale translation after a remap. It also writes a cached page and checks that the write still traps, and overwrites a held mapping in place. Replacement is exercised by filling every entry, freeing one, and touching the oldest. A victim chooser that ignored free entries or recency would then drop a page that is read later, and that read would miss.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   // Kind of software request the cache raises
   typedef enum logic {
      SWK_READ_MISS  = 1'b0,
      SWK_WRITE_TRAP = 1'b1
   } sw_kind_e;

endpackage

// File: rtl/pmc_tag_array.sv
// Entry storage with three compare ports: lookup, fill and invalidate.
module pmc_tag_array #(
   parameter int ENTRIES = 64,
   parameter int PPN_W   = 20,
   parameter int RPN_W   = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PPN_W-1:0]   lk_ppn,
   input  logic [PPN_W-1:0]   fl_ppn,
   input  logic [PPN_W-1:0]   iv_ppn,
   input  logic [ENTRIES-1:0] wr_en,
   input  logic [RPN_W-1:0]   wr_rpn,
   input  logic [ENTRIES-1:0] iv_en,
   output logic [ENTRIES-1:0] valid,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] fl_match,
   output logic [ENTRIES-1:0] iv_match,
   output logic [RPN_W-1:0]   lk_rpn
);

   logic [ENTRIES-1:0][RPN_W-1:0] rpn_masked;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [PPN_W-1:0] tag_q;
      logic [RPN_W-1:0] rpn_q;
      logic             vld_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
            rpn_q <= '0;
         end else if (wr_en[e]) begin
            vld_q <= 1'b1;
            tag_q <= fl_ppn;
            rpn_q <= wr_rpn;
         end else if (iv_en[e]) begin
            vld_q <= 1'b0;
         end
      end

      assign valid[e]      = vld_q;
      assign lk_match[e]   = vld_q && (tag_q == lk_ppn);
      assign fl_match[e]   = vld_q && (tag_q == fl_ppn);
      assign iv_match[e]   = vld_q && (tag_q == iv_ppn);
      assign rpn_masked[e] = lk_match[e] ? rpn_q : '0;
   end

   // At most one entry matches, so an OR tree selects its value
   always_comb begin
      lk_rpn = '0;
      for (int i = 0; i < ENTRIES; i++) lk_rpn = lk_rpn | rpn_masked[i];
   end

endmodule

// File: rtl/pmc_lru.sv
// Recency ranks kept as a permutation of 0..ENTRIES-1; rank 0 is newest.
module pmc_lru #(
   parameter int ENTRIES = 64,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch_en,
   input  logic [IW-1:0]      touch_idx,
   input  logic [ENTRIES-1:0] valid,
   output logic [IW-1:0]      victim_idx
);

   logic [IW-1:0] rank_q [ENTRIES];
   logic [IW-1:0] t_rank;

   assign t_rank = rank_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IW'(i) == touch_idx)       rank_q[i] <= '0;
            else if (rank_q[i] < t_rank)   rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   // Lowest free entry first, otherwise the entry of oldest rank
   always_comb begin
      logic found;
      found      = 1'b0;
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid[i] && !found) begin
            victim_idx = IW'(i);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < ENTRIES; i++)
            if (rank_q[i] == IW'(ENTRIES - 1)) victim_idx = IW'(i);
      end
   end

endmodule

// File: rtl/pmc_map_cache.sv
module pmc_map_cache
   import pmc_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int PPN_W   = 20,
   parameter int RPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [PPN_W-1:0] req_ppn,
   output logic             req_ready,
   output logic             resp_valid,
   output logic             resp_hit,
   output logic [RPN_W-1:0] resp_rpn,
   output logic             sw_req,
   output logic             sw_write,
   output logic [PPN_W-1:0] sw_ppn,
   input  logic             fill_valid,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic [RPN_W-1:0] fill_rpn,
   input  logic             inv_valid,
   input  logic [PPN_W-1:0] inv_ppn
);

   localparam int IW = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pmc_map_cache: ENTRIES must be at least 2");
   end
   if (PPN_W < 1 || RPN_W < 1) begin : g_bad_width
      $error("pmc_map_cache: page number widths must be positive");
   end

   logic [ENTRIES-1:0] valid, lk_match, fl_match, iv_match, wr_en, iv_en;
   logic [RPN_W-1:0]   lk_rpn;
   logic [IW-1:0]      victim_idx, fl_idx, lk_idx, fill_idx, touch_idx;
   logic               touch_en;

   logic               pend_q, wtrap_q;
   logic [PPN_W-1:0]   pend_ppn_q, sw_ppn_q;
   logic               resp_valid_q, resp_hit_q;
   logic [RPN_W-1:0]   resp_rpn_q;

   logic acc, rd_acc, fill_same, inv_same, stored_hit, rd_hit, done_fill;
   logic [RPN_W-1:0] rd_rpn;
   sw_kind_e kind;

   pmc_tag_array #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .RPN_W(RPN_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_ppn   (req_ppn),
      .fl_ppn   (fill_ppn),
      .iv_ppn   (inv_ppn),
      .wr_en    (wr_en),
      .wr_rpn   (fill_rpn),
      .iv_en    (iv_en),
      .valid    (valid),
      .lk_match (lk_match),
      .fl_match (fl_match),
      .iv_match (iv_match),
      .lk_rpn   (lk_rpn)
   );

   pmc_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .valid      (valid),
      .victim_idx (victim_idx)
   );

   // One-hot match vectors to indices
   always_comb begin
      fl_idx = '0;
      lk_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (fl_match[i]) fl_idx = IW'(i);
         if (lk_match[i]) lk_idx = IW'(i);
      end
   end

   assign req_ready  = !pend_q;
   assign acc        = req_valid && !pend_q;
   assign rd_acc     = acc && !req_write;
   assign fill_same  = fill_valid && (fill_ppn == req_ppn);
   assign inv_same   = inv_valid && (inv_ppn == req_ppn);
   assign stored_hit = (|lk_match) && !inv_same;
   assign rd_hit     = fill_same || stored_hit;
   assign rd_rpn     = fill_same ? fill_rpn : lk_rpn;
   assign done_fill  = pend_q && fill_valid && (fill_ppn == pend_ppn_q);

   // A held page is rewritten in place; a new page takes the victim
   assign fill_idx = (|fl_match) ? fl_idx : victim_idx;
   assign wr_en    = fill_valid ? (ENTRIES'(1) << fill_idx) : '0;
   assign iv_en    = inv_valid ? iv_match : '0;

   // A fill claims the recency update over a concurrent read hit
   assign touch_en  = fill_valid || (rd_acc && stored_hit);
   assign touch_idx = fill_valid ? fill_idx : lk_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q       <= 1'b0;
         pend_ppn_q   <= '0;
         wtrap_q      <= 1'b0;
         sw_ppn_q     <= '0;
         resp_valid_q <= 1'b0;
         resp_hit_q   <= 1'b0;
         resp_rpn_q   <= '0;
      end else begin
         wtrap_q      <= acc && req_write;
         resp_valid_q <= (rd_acc && rd_hit) || done_fill;
         resp_hit_q   <= rd_acc && rd_hit;
         if (acc) sw_ppn_q <= req_ppn;
         if (done_fill) begin
            pend_q     <= 1'b0;
            resp_rpn_q <= fill_rpn;
         end else if (rd_acc) begin
            if (rd_hit) resp_rpn_q <= rd_rpn;
            else begin
               pend_q     <= 1'b1;
               pend_ppn_q <= req_ppn;
            end
         end
      end
   end

   assign kind       = wtrap_q ? SWK_WRITE_TRAP : SWK_READ_MISS;
   assign sw_req     = pend_q || wtrap_q;
   assign sw_write   = (kind == SWK_WRITE_TRAP);
   assign sw_ppn     = sw_ppn_q;
   assign resp_valid = resp_valid_q;
   assign resp_hit   = resp_hit_q;
   assign resp_rpn   = resp_rpn_q;

endmodule

// File: rtl/pmc_map_cache_chk.sv
module pmc_map_cache_chk #(
   parameter int ENTRIES = 64,
   parameter int PPN_W   = 20,
   parameter int RPN_W   = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic [PPN_W-1:0]   req_ppn,
   input logic               req_ready,
   input logic               resp_valid,
   input logic               resp_hit,
   input logic [RPN_W-1:0]   resp_rpn,
   input logic               sw_req,
   input logic               sw_write,
   input logic [PPN_W-1:0]   sw_ppn,
   input logic               fill_valid,
   input logic [PPN_W-1:0]   fill_ppn,
   input logic [RPN_W-1:0]   fill_rpn,
   input logic               inv_valid,
   input logic [PPN_W-1:0]   inv_ppn,
   input logic [ENTRIES-1:0] lk_match
);

   AST_WRITE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_write |=> sw_req && sw_write && (sw_ppn == $past(req_ppn)) && !resp_valid && req_ready); // R5

   AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && !sw_write |-> !req_ready); // R3

   AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && !sw_write && !(fill_valid && fill_ppn == sw_ppn) |=> sw_req && !sw_write && $stable(sw_ppn)); // R3

   AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && !sw_write && fill_valid && (fill_ppn == sw_ppn) |=> resp_valid && !resp_hit && (resp_rpn == $past(fill_rpn)) && !sw_req); // R4

   AST_FILL_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_write && fill_valid && (fill_ppn == req_ppn) |=> resp_valid && resp_hit && (resp_rpn == $past(fill_rpn)) && !sw_req); // R8

   AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_write && inv_valid && (inv_ppn == req_ppn) && !(fill_valid && fill_ppn == req_ppn) |=> sw_req && !sw_write); // R7

   AST_UNIQUE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match)); // R6

endmodule

bind pmc_map_cache pmc_map_cache_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .RPN_W(RPN_W)) u_chk (.*);

// File: tb/sim_pmc_map_cache.sv
module sim_pmc_map_cache;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [19:0] req_ppn = '0;
   logic        req_ready, resp_valid, resp_hit, sw_req, sw_write;
   logic [19:0] resp_rpn, sw_ppn;
   logic        fill_valid = 1'b0, inv_valid = 1'b0;
   logic [19:0] fill_ppn = '0, fill_rpn = '0, inv_ppn = '0;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pmc_map_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_ppn(req_ppn),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_rpn(resp_rpn), .sw_req(sw_req), .sw_write(sw_write), .sw_ppn(sw_ppn),
      .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_rpn(fill_rpn),
      .inv_valid(inv_valid), .inv_ppn(inv_ppn)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // Drive one cycle of inputs at a falling edge; outputs are read at the next one
   task automatic step(input logic rv, input logic rw, input logic [19:0] rp,
                       input logic fv, input logic [19:0] fp, input logic [19:0] fr,
                       input logic iv, input logic [19:0] ip);
      req_valid = rv; req_write = rw; req_ppn = rp;
      fill_valid = fv; fill_ppn = fp; fill_rpn = fr;
      inv_valid = iv; inv_ppn = ip;
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_fill(input logic [19:0] p, input logic [19:0] r);
      step(0, 0, 0, 1, p, r, 0, 0);
   endtask

   task automatic expect_hit(input string rq, input logic [19:0] p, input logic [19:0] r);
      step(1, 0, p, 0, 0, 0, 0, 0);
      chk(rq, "hit resp_valid", resp_valid, 1);
      chk(rq, "hit resp_hit", resp_hit, 1);
      chk(rq, "hit resp_rpn", resp_rpn, r);
      chk(rq, "hit sw_req", sw_req, 0);
   endtask

   task automatic check_missing(input string rq, input logic [19:0] p);
      chk(rq, "miss resp_valid", resp_valid, 0);
      chk(rq, "miss sw_req", sw_req, 1);
      chk(rq, "miss sw_write", sw_write, 0);
      chk(rq, "miss sw_ppn", sw_ppn, p);
      chk(rq, "miss req_ready", req_ready, 0);
   endtask

   task automatic expect_miss(input string rq, input logic [19:0] p);
      step(1, 0, p, 0, 0, 0, 0, 0);
      check_missing(rq, p);
   endtask

   task automatic complete(input string rq, input logic [19:0] p, input logic [19:0] r);
      do_fill(p, r);
      chk(rq, "done resp_valid", resp_valid, 1);
      chk(rq, "done resp_hit", resp_hit, 0);
      chk(rq, "done resp_rpn", resp_rpn, r);
      chk(rq, "done sw_req", sw_req, 0);
      chk(rq, "done req_ready", req_ready, 1);
   endtask

   task automatic t_reset_and_basic();
      do_reset();
      chk("R1", "req_ready", req_ready, 1);
      chk("R1", "resp_valid", resp_valid, 0);
      chk("R1", "sw_req", sw_req, 0);
      expect_miss("R1", 20'h5);
      complete("R4", 20'h5, 20'h111);
      expect_hit("R2", 20'h5, 20'h111);
      idle();
      chk("R2", "resp_valid drops", resp_valid, 0);
   endtask

   task automatic t_stall();
      expect_miss("R3", 20'h7);
      step(1, 0, 20'h5, 0, 0, 0, 0, 0);       // ignored while stalled
      check_missing("R3", 20'h7);
      do_fill(20'h9, 20'h999);                 // other page, stall remains
      check_missing("R3", 20'h7);
      repeat (2) idle();
      check_missing("R3", 20'h7);
      complete("R4", 20'h7, 20'h777);
      expect_hit("R4", 20'h7, 20'h777);
      expect_hit("R3", 20'h9, 20'h999);
   endtask

   task automatic t_write();
      step(1, 1, 20'h5, 0, 0, 0, 0, 0);        // page is cached
      chk("R5", "sw_req", sw_req, 1);
      chk("R5", "sw_write", sw_write, 1);
      chk("R5", "sw_ppn", sw_ppn, 20'h5);
      chk("R5", "resp_valid", resp_valid, 0);
      chk("R5", "req_ready", req_ready, 1);
      idle();
      chk("R5", "trap one cycle", sw_req, 0);
      step(1, 1, 20'h1234, 0, 0, 0, 0, 0);     // page not cached
      chk("R5", "uncached sw_write", sw_write, 1);
      chk("R5", "uncached sw_ppn", sw_ppn, 20'h1234);
      expect_hit("R5", 20'h5, 20'h111);
   endtask

   task automatic t_overwrite_and_inv();
      do_fill(20'h5, 20'h222);
      expect_hit("R6", 20'h5, 20'h222);
      step(0, 0, 0, 0, 0, 0, 1, 20'h5);
      expect_miss("R7", 20'h5);
      complete("R7", 20'h5, 20'h333);
      step(1, 0, 20'h5, 0, 0, 0, 1, 20'h5);    // invalidate races the read
      check_missing("R7", 20'h5);
      complete("R7", 20'h5, 20'h444);
      expect_hit("R7", 20'h5, 20'h444);
   endtask

   task automatic t_fill_priority();
      step(1, 0, 20'h42, 1, 20'h42, 20'h4242, 0, 0);
      chk("R8", "resp_valid", resp_valid, 1);
      chk("R8", "resp_hit", resp_hit, 1);
      chk("R8", "resp_rpn", resp_rpn, 20'h4242);
      chk("R8", "sw_req", sw_req, 0);
      do_fill(20'h9, 20'h9999);                 // held page overwritten
      step(1, 0, 20'h9, 1, 20'h9, 20'hABCD, 0, 0);
      chk("R8", "override rpn", resp_rpn, 20'hABCD);
      expect_hit("R8", 20'h42, 20'h4242);
   endtask

   task automatic t_replace();
      do_reset();
      for (int i = 0; i < 64; i++) do_fill(20'(100 + i), 20'(16'h1000 + i));
      step(0, 0, 0, 0, 0, 0, 1, 20'd110);       // frees one entry
      do_fill(20'd600, 20'h6000);               // must use the free entry
      expect_hit("R9", 20'd100, 20'h1000);       // 100 becomes newest
      do_fill(20'd700, 20'h7000);               // evicts 101, now oldest
      expect_hit("R9", 20'd100, 20'h1000);
      expect_hit("R9", 20'd600, 20'h6000);
      expect_hit("R9", 20'd700, 20'h7000);
      expect_hit("R9", 20'd102, 20'h1002);
      expect_hit("R9", 20'd163, 20'h103F);
      expect_miss("R9", 20'd101);
      complete("R9", 20'd101, 20'h1001);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset_and_basic();
      t_stall();
      t_write();
      t_overwrite_and_inv();
      t_fill_priority();
      t_replace();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule